// File: doc/BRIEF.md
# SPI Attenuator Command Decoder

This block is the programmable-logic end of a 24-bit SPI control link for an RF front end. It decodes every frame as one of three kinds: an addressed register access, a table-driven gain command for the receive or transmit chain, or a direct load of the local-oscillator attenuators. A gain command carries an index. The block looks that index up in the band table currently selected for its direction, which yields two 6-bit step-attenuator codes. Write-enable bits in the frame decide which of the two codes are loaded. An LO command carries an attenuation value that goes unchanged into the receive LO attenuator, the transmit LO attenuator, or both.

While the host shifts a frame in, the block shifts a reply out on the same clocks. For gain and LO frames the reply holds the attenuator codes that were current before the frame. For register reads it holds the addressed register. The register space contains a 16-bit scratch register, which lets the host run a loopback check, and a band-select register that chooses between the low-band and high-band gain tables.

The SPI inputs are sampled by the system clock, which must run at least four times faster than the serial clock.

Top module: `atten_spi_decoder`

## Requirements
- R1: A frame takes effect only when chip select (active low) rises after exactly 24 rising edges of the serial clock. A frame with any other edge count changes no state.
- R2: Frame bits 23:22 pick the frame kind: 0 is a register access, 1 a receive gain command, 2 a transmit gain command, 3 an LO command. Bits are sent MSB first.
- R3: In a gain command, bits 21:16 carry an index. Bit 13 loads attenuator 1 and bit 6 loads attenuator 2. Bits 15:14, 12:7 and 5:0 have no effect. An index above 60 changes nothing.
- R4: The gain tables hold these default values. With T = 60 - index, attenuator 1 is ceil(T/2), plus 1 for transmit. Attenuator 2 is floor(T/2), plus 2 when the high-band table is selected.
- R5: In an LO command, bits 21:16 carry an attenuation value from 0 to 30. Bit 13 loads the receive LO attenuator and bit 6 loads the transmit LO attenuator, in any combination. A value above 30 changes nothing.
- R6: During a gain or LO frame, the reply carries the pre-frame code of attenuator 1 (or the receive LO) in bits 12:7. It carries the code of attenuator 2 (or the transmit LO) in bits 5:0. Every other reply bit is 0. The receive attenuators answer kind 1, the transmit attenuators kind 2, the LO attenuators kind 3.
- R7: A register frame carries a 7-bit address in bits 23:17, a read flag in bit 16 (1 = read) and write data in bits 15:0. Address 0x05 is a 16-bit scratch register that reads back the last value written to it.
- R8: At address 0x06, bit 0 selects the high-band receive table and bit 1 the high-band transmit table. The other bits read as 0. A gain command uses the table selected for its direction.
- R9: A register read returns the addressed value in reply bits 15:0 of the same frame. Write frames return an all-zero reply. Unmapped addresses read 0 and ignore writes.
- R10: Reset sets all six attenuator codes to 63, clears the scratch register and selects both low-band tables.
- R11: The link uses SPI mode 0. Reply bit 23 is present once chip select falls, and each later bit follows a falling serial-clock edge. The reply line is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the SPI lines |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial reply to the host |
| rx_att1 | output | 6 | Receive attenuator 1 code |
| rx_att2 | output | 6 | Receive attenuator 2 code |
| tx_att1 | output | 6 | Transmit attenuator 1 code |
| tx_att2 | output | 6 | Transmit attenuator 2 code |
| lo_rx_att | output | 6 | Receive LO attenuator code |
| lo_tx_att | output | 6 | Transmit LO attenuator code |

## Verification
The bench targets four kinds of corner case.

- Frames of 23 and 25 clocks. A decoder that counts loosely would corrupt the scratch register or the attenuators with them.
- Indices and LO values just past their limits (61 and 31). A design without the range check would load garbage codes.
- Single-enable commands. A design that confuses the enable bits would overwrite the wrong attenuator.
- Replies. The bench checks that a reply shows the codes from before its own frame and that a register read returns data in the same frame; an off-by-one in the reply shifter shows up as a shifted or stale word.

It also changes band selection between commands, which exposes a lookup that ignores the selected table or takes the other direction's band.

// File: rtl/atten_spi_decoder.sv
module atten_spi_decoder #(
  parameter int          GAIN_MAX     = 60,
  parameter int          LO_MAX       = 30,
  parameter int          TX_TRIM      = 1,
  parameter int          HB_TRIM      = 2,
  parameter logic [6:0]  SCRATCH_ADDR = 7'h05,
  parameter logic [6:0]  BANDSEL_ADDR = 7'h06
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sclk,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic [5:0] rx_att1,
  output logic [5:0] rx_att2,
  output logic [5:0] tx_att1,
  output logic [5:0] tx_att2,
  output logic [5:0] lo_rx_att,
  output logic [5:0] lo_tx_att
);

  localparam int         FRAME_LEN = 24;
  localparam logic [4:0] LAST_CNT  = 5'(FRAME_LEN);
  localparam logic [4:0] SAT_CNT   = 5'(FRAME_LEN + 1);
  localparam logic [5:0] MAX_CODE  = 6'd63;

  logic        sclk_q, cs_q;
  logic [4:0]  cnt;
  logic [23:0] sh;
  logic [15:0] rep;
  logic [15:0] scratch;
  logic [1:0]  band;

  wire        rise    = spi_sclk & ~sclk_q & ~spi_cs_n;
  wire        fall    = ~spi_sclk & sclk_q & ~spi_cs_n;
  wire        cs_rise = spi_cs_n & ~cs_q;
  wire [23:0] sh_nxt  = {sh[22:0], spi_mosi};
  wire        commit  = cs_rise && (cnt == LAST_CNT);

  wire [1:0]  kind    = sh[23:22];
  wire [5:0]  val     = sh[21:16];
  wire        en1     = sh[13];
  wire        en2     = sh[6];
  wire        is_tx   = (kind == 2'd2);
  wire        hb      = is_tx ? band[1] : band[0];
  wire        idx_ok  = int'(val) <= GAIN_MAX;
  wire        lo_ok   = int'(val) <= LO_MAX;

  function automatic logic [11:0] gain_lookup(input logic tx, input logic high,
                                               input logic [5:0] idx);
    int t, a1, a2;
    t  = GAIN_MAX - int'(idx);
    a1 = (t + 1) / 2 + (tx ? TX_TRIM : 0);
    a2 = t / 2 + (high ? HB_TRIM : 0);
    if (a1 > 63) a1 = 63;
    if (a2 > 63) a2 = 63;
    if (a1 < 0)  a1 = 0;
    if (a2 < 0)  a2 = 0;
    return {a1[5:0], a2[5:0]};
  endfunction

  function automatic logic [15:0] reg_read(input logic [6:0] a);
    if (a == SCRATCH_ADDR)      return scratch;
    else if (a == BANDSEL_ADDR) return {14'd0, band};
    else                        return 16'd0;
  endfunction

  wire [11:0] lut = gain_lookup(is_tx, hb, val);

  logic [5:0] cur1, cur2;
  always_comb begin
    case (sh_nxt[1:0])
      2'd1:    begin cur1 = rx_att1;   cur2 = rx_att2;   end
      2'd2:    begin cur1 = tx_att1;   cur2 = tx_att2;   end
      default: begin cur1 = lo_rx_att; cur2 = lo_tx_att; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      cnt    <= 5'd0;
      sh     <= 24'd0;
      rep    <= 16'd0;
    end else begin
      sclk_q <= spi_sclk;
      cs_q   <= spi_cs_n;
      if (spi_cs_n)
        cnt <= 5'd0;
      else if (rise && cnt != SAT_CNT)
        cnt <= cnt + 5'd1;
      if (rise) begin
        sh <= sh_nxt;
        if (cnt == 5'd1 && sh_nxt[1:0] != 2'd0)
          rep <= {3'd0, cur1, 1'b0, cur2};
        else if (cnt == 5'd6 && sh_nxt[6:5] == 2'd0)
          rep <= reg_read(sh_nxt[6:0]);
        else if (cnt == 5'd7 && sh_nxt[7:6] == 2'd0 && !sh_nxt[0])
          rep <= 16'd0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      spi_miso <= 1'b0;
    else if (spi_cs_n)
      spi_miso <= 1'b0;
    else if (fall) begin
      if (cnt >= 5'd8 && cnt <= 5'd23)
        spi_miso <= rep[4'(5'd23 - cnt)];
      else
        spi_miso <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scratch <= 16'd0;
      band    <= 2'b00;
    end else if (commit && kind == 2'd0 && !sh[16]) begin
      if (sh[23:17] == SCRATCH_ADDR) scratch <= sh[15:0];
      if (sh[23:17] == BANDSEL_ADDR) band    <= sh[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_att1   <= MAX_CODE;
      rx_att2   <= MAX_CODE;
      tx_att1   <= MAX_CODE;
      tx_att2   <= MAX_CODE;
      lo_rx_att <= MAX_CODE;
      lo_tx_att <= MAX_CODE;
    end else if (commit) begin
      case (kind)
        2'd1: if (idx_ok) begin
          if (en1) rx_att1 <= lut[11:6];
          if (en2) rx_att2 <= lut[5:0];
        end
        2'd2: if (idx_ok) begin
          if (en1) tx_att1 <= lut[11:6];
          if (en2) tx_att2 <= lut[5:0];
        end
        2'd3: if (lo_ok) begin
          if (en1) lo_rx_att <= val;
          if (en2) lo_tx_att <= val;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/atten_spi_decoder_chk.sv
module atten_spi_decoder_chk #(
  parameter int LO_MAX = 30
) (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_cs_n,
  input logic       spi_miso,
  input logic [4:0] cnt,
  input logic [5:0] rx_att1,
  input logic [5:0] rx_att2,
  input logic [5:0] tx_att1,
  input logic [5:0] tx_att2,
  input logic [5:0] lo_rx_att,
  input logic [5:0] lo_tx_att,
  input logic [15:0] scratch,
  input logic [1:0] band
);

  a_r1_state_holds_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(spi_cs_n) |=> $stable({rx_att1, rx_att2, tx_att1, tx_att2,
                                  lo_rx_att, lo_tx_att, scratch, band}));

  a_r5_lo_rx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(lo_rx_att) <= LO_MAX) || (lo_rx_att == 6'd63));

  a_r5_lo_tx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(lo_tx_att) <= LO_MAX) || (lo_tx_att == 6'd63));

  a_r11_miso_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n)) |-> !spi_miso);

  a_r6_upper_reply_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt <= 5'd7) |-> !spi_miso);

endmodule

bind atten_spi_decoder atten_spi_decoder_chk #(.LO_MAX(LO_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso), .cnt(cnt),
  .rx_att1(rx_att1), .rx_att2(rx_att2), .tx_att1(tx_att1), .tx_att2(tx_att2),
  .lo_rx_att(lo_rx_att), .lo_tx_att(lo_tx_att), .scratch(scratch), .band(band)
);

// File: tb/atten_spi_decoder_bench.sv
`timescale 1ns/1ps
module atten_spi_decoder_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [5:0] rx1, rx2, tx1, tx2, lor, lot;

  always #4 clk = ~clk;

  atten_spi_decoder u_atten_spi_decoder (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .rx_att1(rx1), .rx_att2(rx2), .tx_att1(tx1), .tx_att2(tx2),
    .lo_rx_att(lor), .lo_tx_att(lot)
  );

  int checks = 0, fails = 0;
  bit done = 0, live = 0;
  int m_rx1 = 63, m_rx2 = 63, m_tx1 = 63, m_tx2 = 63, m_lor = 63, m_lot = 63;
  int m_scr = 0, m_band = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (live) begin
    check("R3 rx_att1", rx1, m_rx1);
    check("R3 rx_att2", rx2, m_rx2);
    check("R3 tx_att1", tx1, m_tx1);
    check("R3 tx_att2", tx2, m_tx2);
    check("R5 lo_rx", lor, m_lor);
    check("R5 lo_tx", lot, m_lot);
    if (cs_n) check("R11 miso idle", miso, 0);
  end

  task automatic tick; @(posedge clk); #1; endtask

  function automatic int reg_value(input int a);
    if (a == 5) return m_scr;
    if (a == 6) return m_band;
    return 0;
  endfunction

  function automatic logic [23:0] exp_reply(input logic [23:0] w);
    int c1, c2;
    case (w[23:22])
      2'd0: return w[16] ? 24'(reg_value(int'(w[23:17]))) : 24'd0;
      2'd1: begin c1 = m_rx1; c2 = m_rx2; end
      2'd2: begin c1 = m_tx1; c2 = m_tx2; end
      default: begin c1 = m_lor; c2 = m_lot; end
    endcase
    return 24'((c1 << 7) | c2);
  endfunction

  task automatic apply_model(input logic [23:0] w);
    int v, t, hi;
    v = int'(w[21:16]);
    case (w[23:22])
      2'd0: if (!w[16]) begin
        if (w[23:17] == 7'h05) m_scr = int'(w[15:0]);
        if (w[23:17] == 7'h06) m_band = int'(w[1:0]);
      end
      2'd1, 2'd2: if (v <= 60) begin
        t  = 60 - v;
        hi = (w[23:22] == 2'd1) ? (m_band & 1) : ((m_band >> 1) & 1);
        if (w[23:22] == 2'd1) begin
          if (w[13]) m_rx1 = (t + 1) / 2;
          if (w[6])  m_rx2 = t / 2 + (hi ? 2 : 0);
        end else begin
          if (w[13]) m_tx1 = (t + 1) / 2 + 1;
          if (w[6])  m_tx2 = t / 2 + (hi ? 2 : 0);
        end
      end
      default: if (v <= 30) begin
        if (w[13]) m_lor = v;
        if (w[6])  m_lot = v;
      end
    endcase
  endtask

  task automatic frame(input string tag, input logic [23:0] w, input int n);
    logic [23:0] r = 24'd0;
    logic [23:0] e;
    e = exp_reply(w);
    cs_n = 1'b0; tick; tick;
    for (int i = 0; i < n; i++) begin
      mosi = (i < 24) ? w[23 - i] : 1'b0;
      tick; tick;
      r = {r[22:0], miso};
      sclk = 1'b1; tick; tick;
      sclk = 1'b0;
    end
    tick; tick;
    cs_n = 1'b1; mosi = 1'b0;
    tick;
    if (n == 24) begin
      apply_model(w);
      check(tag, int'(r), int'(e));
    end
    tick; tick;
  endtask

  function automatic logic [23:0] wr(input int a, input int d);
    return 24'((a << 17) | (d & 16'hFFFF));
  endfunction
  function automatic logic [23:0] rd(input int a);
    return 24'((a << 17) | (1 << 16));
  endfunction
  function automatic logic [23:0] cmd(input int k, input int v, input bit e1, input bit e2);
    return 24'((k << 22) | (v << 16) | (int'(e1) << 13) | (int'(e2) << 6));
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) tick;
    rst_n = 1'b1;
    tick;
    live = 1;
    check("R10 reset rx_att1", rx1, 63);
    check("R10 reset lo_tx", lot, 63);
    frame("R10 scratch cleared", rd(5), 24);
    frame("R10 low band", rd(6), 24);
    frame("R7 scratch write reply", wr(5, 16'hA5C3), 24);
    frame("R7 scratch readback", rd(5), 24);
    frame("R6 rx gain reply pre-frame", cmd(1, 10, 1, 1), 24);
    frame("R4 tx gain en1 only", cmd(2, 0, 1, 0), 24);
    frame("R6 tx reply", cmd(2, 0, 0, 0), 24);
    frame("R8 band write", wr(6, 3), 24);
    frame("R8 band read", rd(6), 24);
    frame("R8 rx high band idx60", cmd(1, 60, 0, 1), 24);
    frame("R3 reserved bits", 24'(cmd(1, 20, 1, 0) | 24'h00C000 | 24'h000F80 | 24'h00003F), 24);
    frame("R3 index 61 ignored", cmd(1, 61, 1, 1), 24);
    frame("R6 rx reply after ignore", cmd(1, 0, 0, 0), 24);
    frame("R8 tx high band", cmd(2, 33, 1, 1), 24);
    frame("R8 band upper bits", wr(6, 16'hFFFC), 24);
    frame("R8 band readback", rd(6), 24);
    frame("R5 lo both", cmd(3, 12, 1, 1), 24);
    frame("R5 lo value 31 ignored", cmd(3, 31, 1, 1), 24);
    frame("R5 lo tx only", cmd(3, 5, 0, 1), 24);
    frame("R6 lo reply", cmd(3, 30, 1, 0), 24);
    frame("R1 short frame", wr(5, 16'h1234), 23);
    frame("R1 long frame", wr(5, 16'h5678), 25);
    frame("R1 scratch unchanged", rd(5), 24);
    frame("R9 unmapped write", wr(16, 16'hBEEF), 24);
    frame("R9 unmapped read", rd(16), 24);
    frame("R2 kind decode rx", cmd(1, 40, 1, 1), 24);
    frame("R11 reply alignment", rd(5), 24);
    repeat (4) tick;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule